// File: doc/BRIEF.md
# Control Endpoint Handshake Arbiter

This block picks the handshake answer for every token addressed to control endpoint zero. Software programs a stage direction and, for each direction, a force-NAK flag and a force-STALL flag through a small register port. The serial engine pulses a strobe when a setup stage finishes, and the block then raises both force-NAK flags by itself. Software clears them once it has decoded the request and is ready for the data or status stage.

For each IN or OUT token, the block weighs three things: the flags for the token's own direction, the programmed direction, and the FIFO readiness for that direction. One clock after the token it returns ACK, NAK or STALL. A token against the programmed direction is refused with NAK, unless the STALL flag for the token's direction is set. For the status stage, software flips the direction bit to the opposite of the data stage, or sets it to IN when there was no data stage. The block itself only enforces what is programmed.

Top module: `ep0_hs_arb`

## Requirements
- R1: After reset the direction bit is 0 (OUT), all four flags are 0 and hs_valid_o is low with hs_code_o = 2'b00.
- R2: Writing address 0 stores data bit 7 as the direction bit (1 = IN, 0 = OUT). Reading address 0 returns it in bit 7.
- R3: Bits 6 to 0 of address 0 always read as 0, whatever was written to them.
- R4: A setup_done_i pulse sets both force-NAK flags at the next clock edge. It takes precedence over a register write in the same cycle. A later write of 0 clears a flag.
- R5: A token whose own direction has its force-STALL flag set is answered STALL (2'b11), regardless of direction, force-NAK or FIFO state.
- R6: Without STALL, a token whose direction differs from the direction bit is answered NAK (2'b10).
- R7: Without STALL, a matching token whose direction has its force-NAK flag set is answered NAK.
- R8: Otherwise an IN token gets ACK (2'b01) when fifo_has_data_i is high, and an OUT token gets ACK when fifo_has_space_i is high. Each gets NAK when its FIFO input is low.
- R9: hs_valid_o is high for exactly one cycle, the cycle after a tok_valid_i cycle. Whenever hs_valid_o is low, hs_code_o is 2'b00.
- R10: Address 1 holds the IN flags and address 2 the OUT flags, with force-NAK in bit 0 and force-STALL in bit 1. Their other bits, and every bit of address 3, read as 0. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | ADDR_W | Register address for read and write |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i |
| setup_done_i | input | 1 | Pulse: setup stage completed |
| tok_valid_i | input | 1 | Token for endpoint zero this cycle |
| tok_in_i | input | 1 | Token direction, 1 = IN, 0 = OUT |
| fifo_has_data_i | input | 1 | IN FIFO can supply a packet |
| fifo_has_space_i | input | 1 | OUT FIFO can accept a packet |
| hs_valid_o | output | 1 | Handshake code valid |
| hs_code_o | output | 2 | 00 none, 01 ACK, 10 NAK, 11 STALL |

## Verification
The bench builds the block with the default ADDR_W = 2 and DATA_W = 8, so the direction bit sits in bit 7. With these defaults, random addresses also hit the unmapped fourth location, and the read-as-zero behaviour of every unused bit is checked. Random writes, setup pulses and tokens are mixed, so that STALL, force-NAK, direction mismatch and FIFO readiness meet in every combination. Directed cases cover a setup pulse that collides with a flag write.

// File: rtl/ep0_hs_pkg.sv
package ep0_hs_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_code_e;

  localparam int DIR_OUT   = 0;
  localparam int DIR_IN    = 1;
  localparam int NUM_DIR   = 2;
  localparam int NAK_BIT   = 0;
  localparam int STALL_BIT = 1;
endpackage

// File: rtl/ep0_hs_regs.sv
module ep0_hs_regs
  import ep0_hs_pkg::*;
#(
  parameter int              ADDR_W    = 2,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'd0,
  parameter logic [ADDR_W-1:0] IN_ADDR   = 'd1,
  parameter logic [ADDR_W-1:0] OUT_ADDR  = 'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              setup_done_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dir_in_o,
  output logic [NUM_DIR-1:0] nak_o,
  output logic [NUM_DIR-1:0] stall_o
);
  localparam int DIR_BIT = DATA_W - 1;

  logic dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          dir_q <= 1'b0;
    else if (we_i && addr_i == CTRL_ADDR) dir_q <= wdata_i[DIR_BIT];
  end

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    localparam logic [ADDR_W-1:0] A = (d == DIR_IN) ? IN_ADDR : OUT_ADDR;
    logic nak_q, stall_q;

    // setup completion outranks a same-cycle software write
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  nak_q <= 1'b0;
      else if (setup_done_i)        nak_q <= 1'b1;
      else if (we_i && addr_i == A) nak_q <= wdata_i[NAK_BIT];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  stall_q <= 1'b0;
      else if (we_i && addr_i == A) stall_q <= wdata_i[STALL_BIT];
    end

    assign nak_o[d]   = nak_q;
    assign stall_o[d] = stall_q;
  end

  assign dir_in_o = dir_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR) begin
      rdata_o[DIR_BIT] = dir_q;
    end else if (addr_i == IN_ADDR) begin
      rdata_o[NAK_BIT]   = nak_o[DIR_IN];
      rdata_o[STALL_BIT] = stall_o[DIR_IN];
    end else if (addr_i == OUT_ADDR) begin
      rdata_o[NAK_BIT]   = nak_o[DIR_OUT];
      rdata_o[STALL_BIT] = stall_o[DIR_OUT];
    end
  end
endmodule

// File: rtl/ep0_hs_decide.sv
module ep0_hs_decide
  import ep0_hs_pkg::*;
(
  input  logic               tok_in_i,
  input  logic               dir_in_i,
  input  logic [NUM_DIR-1:0] nak_i,
  input  logic [NUM_DIR-1:0] stall_i,
  input  logic               fifo_has_data_i,
  input  logic               fifo_has_space_i,
  output hs_code_e           code_o
);
  logic fifo_ok;
  assign fifo_ok = tok_in_i ? fifo_has_data_i : fifo_has_space_i;

  always_comb begin
    if (stall_i[tok_in_i])                         code_o = HS_STALL;
    else if (tok_in_i != dir_in_i || nak_i[tok_in_i]) code_o = HS_NAK;
    else if (fifo_ok)                              code_o = HS_ACK;
    else                                           code_o = HS_NAK;
  end
endmodule

// File: rtl/ep0_hs_out.sv
module ep0_hs_out
  import ep0_hs_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tok_valid_i,
  input  hs_code_e code_i,
  output logic     valid_o,
  output hs_code_e code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= HS_NONE;
    end else begin
      valid_o <= tok_valid_i;
      code_o  <= tok_valid_i ? code_i : HS_NONE;
    end
  end
endmodule

// File: rtl/ep0_hs_arb.sv
module ep0_hs_arb
  import ep0_hs_pkg::*;
#(
  parameter int              ADDR_W    = 2,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'd0,
  parameter logic [ADDR_W-1:0] IN_ADDR   = 'd1,
  parameter logic [ADDR_W-1:0] OUT_ADDR  = 'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              setup_done_i,
  input  logic              tok_valid_i,
  input  logic              tok_in_i,
  input  logic              fifo_has_data_i,
  input  logic              fifo_has_space_i,
  output logic              hs_valid_o,
  output logic [1:0]        hs_code_o
);
  logic               dir_q;
  logic [NUM_DIR-1:0] nak_q;
  logic [NUM_DIR-1:0] stall_q;
  hs_code_e           code_d;
  hs_code_e           code_q;

  ep0_hs_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_ADDR(CTRL_ADDR), .IN_ADDR(IN_ADDR), .OUT_ADDR(OUT_ADDR)
  ) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .setup_done_i(setup_done_i),
    .rdata_o     (reg_rdata_o),
    .dir_in_o    (dir_q),
    .nak_o       (nak_q),
    .stall_o     (stall_q)
  );

  ep0_hs_decide decide_i (
    .tok_in_i        (tok_in_i),
    .dir_in_i        (dir_q),
    .nak_i           (nak_q),
    .stall_i         (stall_q),
    .fifo_has_data_i (fifo_has_data_i),
    .fifo_has_space_i(fifo_has_space_i),
    .code_o          (code_d)
  );

  ep0_hs_out out_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tok_valid_i(tok_valid_i),
    .code_i     (code_d),
    .valid_o    (hs_valid_o),
    .code_o     (code_q)
  );

  assign hs_code_o = code_q;
endmodule

// File: rtl/ep0_hs_arb_chk.sv
module ep0_hs_arb_chk #(
  parameter int              ADDR_W    = 2,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'd0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              setup_done_i,
  input logic              tok_valid_i,
  input logic              tok_in_i,
  input logic              dir_q,
  input logic [1:0]        nak_q,
  input logic [1:0]        stall_q,
  input logic              hs_valid_o,
  input logic [1:0]        hs_code_o
);
  assert_ctrl_rsv_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == CTRL_ADDR) |-> (reg_rdata_o[DATA_W-2:0] == '0));

  assert_setup_sets_nak_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_done_i |=> (nak_q == 2'b11));

  assert_stall_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && stall_q[tok_in_i]) |=> (hs_code_o == 2'b11));

  assert_mismatch_nak_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && !stall_q[tok_in_i] && tok_in_i != dir_q) |=> (hs_code_o == 2'b10));

  assert_force_nak_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_valid_i && !stall_q[tok_in_i] && nak_q[tok_in_i]) |=> (hs_code_o == 2'b10));

  assert_hs_follows_tok_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_i |=> hs_valid_o);

  assert_hs_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tok_valid_i |=> (!hs_valid_o && hs_code_o == 2'b00));
endmodule

bind ep0_hs_arb ep0_hs_arb_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .setup_done_i(setup_done_i),
  .tok_valid_i (tok_valid_i),
  .tok_in_i    (tok_in_i),
  .dir_q       (dir_q),
  .nak_q       (nak_q),
  .stall_q     (stall_q),
  .hs_valid_o  (hs_valid_o),
  .hs_code_o   (hs_code_o)
);

// File: tb/ep0_hs_arb_tb.sv
`timescale 1ns/1ps
module ep0_hs_arb_tb_top;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_we_i = 1'b0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic [DATA_W-1:0] reg_wdata_i = '0;
  logic [DATA_W-1:0] reg_rdata_o;
  logic              setup_done_i = 1'b0;
  logic              tok_valid_i = 1'b0;
  logic              tok_in_i = 1'b0;
  logic              fifo_has_data_i = 1'b0;
  logic              fifo_has_space_i = 1'b0;
  logic              hs_valid_o;
  logic [1:0]        hs_code_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // bench model
  logic       m_dir;
  logic [1:0] m_nak, m_stall;

  always #4 clk_i = ~clk_i;

  ep0_hs_arb dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .setup_done_i(setup_done_i),
    .tok_valid_i(tok_valid_i), .tok_in_i(tok_in_i),
    .fifo_has_data_i(fifo_has_data_i), .fifo_has_space_i(fifo_has_space_i),
    .hs_valid_o(hs_valid_o), .hs_code_o(hs_code_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return {m_dir, 7'b0};
      2'd1:    return {6'b0, m_stall[1], m_nak[1]};
      2'd2:    return {6'b0, m_stall[0], m_nak[0]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(input logic [1:0] a);
    return (a == 2'd0) ? "R2/R3" : "R10";
  endfunction

  function automatic logic [1:0] exp_hs(input logic tin, input logic fd, input logic fs);
    if (m_stall[tin])                 return 2'b11;
    if (tin != m_dir || m_nak[tin])   return 2'b10;
    if (tin ? fd : fs)                return 2'b01;
    return 2'b10;
  endfunction

  function automatic string hs_tag(input logic tin);
    if (m_stall[tin]) return "R5";
    if (tin != m_dir) return "R6";
    if (m_nak[tin])   return "R7";
    return "R8";
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] wd,
                      input logic su, input logic tv, input logic tin,
                      input logic fd, input logic fs);
    logic [1:0] e;
    string      tag;
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    setup_done_i = su; tok_valid_i = tv; tok_in_i = tin;
    fifo_has_data_i = fd; fifo_has_space_i = fs;
    #1;
    check({read_tag(a), " read"}, reg_rdata_o, exp_read(a));
    e   = tv ? exp_hs(tin, fd, fs) : 2'b00;
    tag = tv ? hs_tag(tin) : "R9";
    if (we && a == 2'd0) m_dir = wd[7];
    for (int d = 0; d < 2; d++) begin
      logic [1:0] fa;
      fa = (d == 1) ? 2'd1 : 2'd2;
      if (su)                 m_nak[d] = 1'b1;
      else if (we && a == fa) m_nak[d] = wd[0];
      if (we && a == fa)      m_stall[d] = wd[1];
    end
    @(posedge clk_i);
    @(negedge clk_i);
    check("R9 valid", hs_valid_o, tv);
    check({tag, " code"}, hs_code_o, e);
    reg_we_i = 1'b0; setup_done_i = 1'b0; tok_valid_i = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 2'd3, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    m_dir = 1'b0; m_nak = 2'b00; m_stall = 2'b00;
    void'($urandom(32'h0E0C_A11B));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_addr_i = a[1:0]; #1;
      check("R1 reset read", reg_rdata_o, 8'h00);
    end
    check("R1 reset valid", hs_valid_o, 1'b0);
    check("R1 reset code", hs_code_o, 2'b00);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2/R3: all-ones write to control keeps only the direction bit
    step(1'b1, 2'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle();
    step(1'b1, 2'd0, 8'h7F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    idle();
    // R8: OUT matching, FIFO space and no space
    step(1'b0, 2'd3, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b0, 2'd3, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    // R6: IN against OUT direction
    step(1'b0, 2'd3, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    // R4: setup collides with a clearing write, setup wins
    step(1'b1, 2'd2, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle();
    // R7: force-NAK blocks matching OUT
    step(1'b0, 2'd3, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    // R4: software clears, then ACK again
    step(1'b1, 2'd2, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'd3, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    // R5: stall on IN beats mismatch
    step(1'b1, 2'd1, 8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 2'd1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    // R9: back-to-back tokens
    step(1'b0, 2'd3, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b0, 2'd3, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    idle();

    for (int i = 0; i < 4000; i++) begin
      logic       we, su, tv;
      logic [1:0] a;
      we = ($urandom % 100) < 25;
      su = ($urandom % 100) < 8;
      tv = ($urandom % 100) < 60;
      a  = 2'($urandom);
      step(we, a, 8'($urandom), su, tv, 1'($urandom),
           1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule